// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block controls one processor's private, direct-mapped, write-back cache in a multiprocessor that shares one atomic bus. It keeps its copies coherent with the other caches by watching every transaction those caches place on the bus. A line is in one of three states. Invalid means it holds nothing. Shared means it holds a clean, read-only copy that other caches may also hold. Exclusive means this cache is the only holder and its copy is modified.

On the processor side, a read or write request is held until `cpu_done` pulses, and `cpu_stall` reports that the request is waiting. On the bus side, the controller raises a request and holds a command and an address until the arbiter grants it. It then waits for fill data from whoever answers. Other masters' transactions arrive on the snoop inputs. If the controller owns the requested line, it drives the line's data and raises an abort one cycle later, so that memory stays silent.

Each cache line holds one data word. An address is split into a line index (the low `IDX_W` bits) and a tag (the remaining upper bits).

Top module: `snoop_inval_ctrl`

## Requirements
- R1: After reset every line is invalid, and `bus_req`, `snp_abort`, `cpu_stall` and `cpu_done` are all low.
- R2: A read whose line is valid with a matching tag completes with `cpu_done` in the cycle it is presented, returns the line data on `cpu_rdata`, and raises no bus request.
- R3: A read miss places a read-miss command (code 1) with the requested address on the bus, installs the returned fill word as a shared line, and later reads of that address hit.
- R4: A write to a matching exclusive line completes in the cycle it is presented with no bus request, and later reads return the written word.
- R5: A write to a matching shared line places a write-miss command (code 2) on the bus, and the line becomes exclusive holding the written word.
- R6: A write to an invalid or non-matching line places a write-miss command (code 2) on the bus, and the line becomes exclusive.
- R7: A miss whose index holds an exclusive line with another tag first places a write-back command (code 3) carrying the victim address and data, and only then the miss command.
- R8: While `bus_req` is high and no grant has arrived, the request stays high and the command and address do not change. Command 0 means idle and is driven whenever there is no request.
- R9: A snooped read-miss (code 1) to a line held exclusive gives `snp_abort` high with the line data on `snp_data` in the following cycle, and the line drops to shared.
- R10: A snooped write-miss (code 2) to a held line invalidates it. If the line was exclusive, it also aborts and supplies the data as in R9.
- R11: A snooped write-back (code 3), or a snoop to a line that is not held, gives no abort and leaves the line unchanged. A snooped read-miss to a shared line also gives no abort.
- R12: If a snoop takes ownership away from the victim while its write-back is still waiting for a grant, the write-back is dropped and the controller requests the miss directly.
- R13: `cpu_stall` is high from the cycle a miss is detected until the cycle after the fill word is written into the line. `cpu_done` never accompanies a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_rd | input | 1 | Processor read request, held until done |
| cpu_wr | input | 1 | Processor write request, held until done |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_rdata | output | DATA_W | Read word of the addressed line |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the transaction occurs in a granted cycle |
| bus_cmd | output | 2 | Command: 0 idle, 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_fill_vld | input | 1 | Fill word valid |
| bus_fill_data | input | DATA_W | Fill word |
| snp_vld | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_abort | output | 1 | Owner response: memory must not answer |
| snp_data | output | DATA_W | Owner data supplied with the abort |

## Verification
The hardest situation to reach is R12. It needs a dirty victim whose write-back is already queued and waiting for a grant while another master snoops that same victim line. A random bus never lines these events up by chance. So the bench has a directed mode that withholds the grant once the write-back appears and injects a snooped read-miss to the victim address. It then checks the abort data and that the next command is the miss with no write-back before it. The random phase draws addresses from a small pool so that conflict evictions and snoop hits on lines in all three states happen often. It also holds grants back for random stretches so that the request-holding rule is exercised.

// File: rtl/snp_pkg.sv
package snp_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_WBREQ   = 2'd1,
        CS_MISSREQ = 2'd2,
        CS_FILL    = 2'd3
    } ctl_st_e;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
    import snp_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sn_en,
    input  logic [IDX_W-1:0]  sn_idx,
    input  line_st_e          sn_st
);
    localparam int NLINES = 1 << IDX_W;

    typedef struct packed {
        line_st_e          st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t lines_q [NLINES];
    line_t lines_d [NLINES];

    always_comb begin
        for (int i = 0; i < NLINES; i++) begin
            lines_d[i] = lines_q[i];
            if (wr_en && wr_idx == IDX_W'(i)) begin
                lines_d[i].st   = wr_st;
                lines_d[i].tag  = wr_tag;
                lines_d[i].data = wr_data;
            end
            // the bus order puts a snooped transaction first, so its state wins
            if (sn_en && sn_idx == IDX_W'(i)) begin
                lines_d[i].st = sn_st;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                lines_q[i] <= '{st: LN_INV, tag: '0, data: '0};
            end
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                lines_q[i] <= lines_d[i];
            end
        end
    end

    assign a_st   = lines_q[a_idx].st;
    assign a_tag  = lines_q[a_idx].tag;
    assign a_data = lines_q[a_idx].data;
    assign b_st   = lines_q[b_idx].st;
    assign b_tag  = lines_q[b_idx].tag;
    assign b_data = lines_q[b_idx].data;
endmodule

// File: rtl/snp_snoop_unit.sv
module snp_snoop_unit
    import snp_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             vld,
    input  logic [1:0]       cmd,
    input  logic [TAG_W-1:0] tag,
    input  line_st_e         ln_st,
    input  logic [TAG_W-1:0] ln_tag,
    output logic             upd,
    output line_st_e         new_st,
    output logic             abort
);
    logic held;

    always_comb begin
        held   = vld && (ln_st != LN_INV) && (ln_tag == tag);
        upd    = 1'b0;
        new_st = ln_st;
        abort  = 1'b0;
        if (held) begin
            case (bus_cmd_e'(cmd))
                BC_RDMISS: begin
                    if (ln_st == LN_EXC) begin
                        upd    = 1'b1;
                        new_st = LN_SHR;
                        abort  = 1'b1;
                    end
                end
                BC_WRMISS: begin
                    upd    = 1'b1;
                    new_st = LN_INV;
                    abort  = (ln_st == LN_EXC);
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/snoop_inval_ctrl.sv
module snoop_inval_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_stall,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_fill_vld,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_vld,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           ctl;
        logic              abort;
        logic [DATA_W-1:0] sdata;
    } state_t;

    state_t s_q, s_d;

    logic [IDX_W-1:0]  cpu_idx, sn_idx;
    logic [TAG_W-1:0]  cpu_tag, sn_tag;
    line_st_e          c_st, s_st, wr_st, sn_new_st;
    logic [TAG_W-1:0]  c_tag, s_tag, wr_tag;
    logic [DATA_W-1:0] c_data, s_data, wr_data;
    logic              wr_en, sn_upd, sn_abort;
    logic              cpu_req, tag_match, snp_clash, hit_ok, victim_dirty;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign sn_idx  = snp_addr[IDX_W-1:0];
    assign sn_tag  = snp_addr[ADDR_W-1:IDX_W];

    snp_line_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (cpu_idx),
        .a_st   (c_st),
        .a_tag  (c_tag),
        .a_data (c_data),
        .b_idx  (sn_idx),
        .b_st   (s_st),
        .b_tag  (s_tag),
        .b_data (s_data),
        .wr_en  (wr_en),
        .wr_idx (cpu_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .sn_en  (sn_upd),
        .sn_idx (sn_idx),
        .sn_st  (sn_new_st)
    );

    snp_snoop_unit #(
        .TAG_W(TAG_W)
    ) u_snoop (
        .vld   (snp_vld),
        .cmd   (snp_cmd),
        .tag   (sn_tag),
        .ln_st (s_st),
        .ln_tag(s_tag),
        .upd   (sn_upd),
        .new_st(sn_new_st),
        .abort (sn_abort)
    );

    // processor-side decode
    always_comb begin
        cpu_req      = cpu_rd || cpu_wr;
        tag_match    = (c_st != LN_INV) && (c_tag == cpu_tag);
        snp_clash    = snp_vld && (sn_idx == cpu_idx);
        hit_ok       = (s_q.ctl == CS_IDLE) && cpu_req && !snp_clash && tag_match &&
                       (!cpu_wr || c_st == LN_EXC);
        victim_dirty = (c_st == LN_EXC) && (c_tag != cpu_tag);
    end

    // next-state computation
    always_comb begin
        s_d       = s_q;
        s_d.abort = sn_abort;
        s_d.sdata = sn_abort ? s_data : '0;
        wr_en     = 1'b0;
        wr_st     = c_st;
        wr_tag    = c_tag;
        wr_data   = c_data;
        case (s_q.ctl)
            CS_IDLE: begin
                if (hit_ok && cpu_wr) begin
                    wr_en   = 1'b1;
                    wr_data = cpu_wdata;
                end else if (cpu_req && !hit_ok && !snp_clash) begin
                    s_d.ctl = victim_dirty ? CS_WBREQ : CS_MISSREQ;
                end
            end
            CS_WBREQ: begin
                if (bus_gnt) begin
                    wr_en   = 1'b1;
                    wr_st   = LN_INV;
                    s_d.ctl = CS_MISSREQ;
                end else if (sn_upd && sn_idx == cpu_idx && sn_new_st != LN_EXC) begin
                    s_d.ctl = CS_MISSREQ;
                end
            end
            CS_MISSREQ: begin
                if (bus_gnt) begin
                    s_d.ctl = CS_FILL;
                end
            end
            CS_FILL: begin
                if (bus_fill_vld) begin
                    wr_en   = 1'b1;
                    wr_st   = cpu_wr ? LN_EXC : LN_SHR;
                    wr_tag  = cpu_tag;
                    wr_data = bus_fill_data;
                    s_d.ctl = CS_IDLE;
                end
            end
            default: s_d.ctl = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ctl: CS_IDLE, abort: 1'b0, sdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_req   = (s_q.ctl == CS_WBREQ) || (s_q.ctl == CS_MISSREQ);
        bus_cmd   = BC_IDLE;
        bus_addr  = '0;
        bus_wdata = '0;
        if (s_q.ctl == CS_WBREQ) begin
            bus_cmd   = BC_WBACK;
            bus_addr  = {c_tag, cpu_idx};
            bus_wdata = c_data;
        end else if (s_q.ctl == CS_MISSREQ) begin
            bus_cmd  = cpu_wr ? BC_WRMISS : BC_RDMISS;
            bus_addr = cpu_addr;
        end
    end

    assign cpu_rdata = c_data;
    assign cpu_done  = hit_ok;
    assign cpu_stall = cpu_req && !hit_ok;
    assign snp_abort = s_q.abort;
    assign snp_data  = s_q.sdata;
endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              cpu_stall,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_vld,
    input logic [1:0]        snp_cmd,
    input logic              snp_abort,
    input logic [DATA_W-1:0] snp_data
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req); // R8
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt && !snp_vld |=> $stable(bus_cmd) && $stable(bus_addr)); // R8
    AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> bus_cmd == 2'd0); // R8
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> $past(snp_vld) && ($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2)); // R11
    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_abort |-> snp_data == '0); // R9
    AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_stall && !cpu_done); // R13
    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && bus_cmd == 2'd3 |=> bus_req && bus_cmd != 2'd3); // R7
endmodule

bind snoop_inval_ctrl snp_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_done (cpu_done),
    .cpu_stall(cpu_stall),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_cmd  (bus_cmd),
    .bus_addr (bus_addr),
    .snp_vld  (snp_vld),
    .snp_cmd  (snp_cmd),
    .snp_abort(snp_abort),
    .snp_data (snp_data)
);

// File: tb/snoop_inval_ctrl_tb.sv
module snoop_inval_ctrl_tb;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int DW = 16;
    localparam int NL = 1 << IW;
    localparam int TW = AW - IW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cpu_rd, cpu_wr, cpu_done, cpu_stall, bus_req, bus_gnt, bus_fill_vld;
    logic snp_vld, snp_abort;
    logic [AW-1:0] cpu_addr, bus_addr, snp_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata, bus_wdata, bus_fill_data, snp_data;
    logic [1:0] bus_cmd, snp_cmd;

    snoop_inval_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_fill_vld(bus_fill_vld), .bus_fill_data(bus_fill_data),
        .snp_vld(snp_vld), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_abort(snp_abort), .snp_data(snp_data));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] mem [1 << AW];
    int            ex_st  [NL];   // 0 invalid, 1 shared, 2 exclusive
    logic [TW-1:0] ex_tag [NL];
    logic [DW-1:0] ex_dat [NL];

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit cut_wb);
        int idx;
        logic [TW-1:0] tg;
        bit hit, local_ok, need_wb, done, sn_pend;
        logic [1:0] ecmd [2];
        logic [AW-1:0] eadr [2];
        int ne, step, fill_cnt, gwait;
        string rq;
        idx = int'(a[IW-1:0]);
        tg = a[AW-1:IW];
        hit = ex_st[idx] != 0 && ex_tag[idx] == tg;
        local_ok = hit && (!wr || ex_st[idx] == 2);
        need_wb = ex_st[idx] == 2 && ex_tag[idx] != tg;
        ne = 0; step = 0; fill_cnt = -1; done = 0; sn_pend = 0; gwait = -1;
        if (!local_ok) begin
            if (need_wb) begin
                ecmd[0] = 2'd3; eadr[0] = {ex_tag[idx], a[IW-1:0]}; ne = 1;
            end
            ecmd[ne] = wr ? 2'd2 : 2'd1; eadr[ne] = a; ne++;
        end
        rq = wr ? (hit ? (local_ok ? "R4" : "R5") : "R6") : (hit ? "R2" : "R3");
        cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        for (int cyc = 0; cyc < 100 && !done; cyc++) begin
            #1;
            bus_gnt = 0; bus_fill_vld = 0; snp_vld = 0;
            if (sn_pend) begin
                sn_pend = 0;
                chk("R12", "abort for pending victim", snp_abort, 1);
                chk("R12", "victim data supplied", snp_data, ex_dat[idx]);
                mem[eadr[0]] = ex_dat[idx];
                ex_st[idx] = 1;
                step = 1;
            end
            if (cyc == 0) chk(rq, "stall on entry (R13)", cpu_stall, !local_ok);
            if (cpu_done) begin
                done = 1;
                chk(rq, "bus transactions used", step, ne);
                chk("R13", "stall low at completion", cpu_stall, 0);
                if (!wr) chk(rq, "read data", cpu_rdata, hit ? ex_dat[idx] : mem[a]);
            end else begin
                chk("R13", "stall while pending", cpu_stall, 1);
                if (fill_cnt > 0) begin
                    fill_cnt--;
                    if (fill_cnt == 0) begin
                        bus_fill_vld = 1; bus_fill_data = mem[a]; fill_cnt = -1;
                    end
                end
                if (bus_req) begin
                    if (step >= ne) begin
                        chk(rq, "unexpected bus request", 1, 0);
                    end else begin
                        chk(gwait > 0 ? "R8" : rq, "bus command", bus_cmd, ecmd[step]);
                        chk(gwait > 0 ? "R8" : rq, "bus address", bus_addr, eadr[step]);
                        if (ecmd[step] == 2'd3) chk("R7", "write-back data", bus_wdata, ex_dat[idx]);
                        if (cut_wb && ecmd[step] == 2'd3) begin
                            snp_vld = 1; snp_cmd = 2'd1; snp_addr = eadr[0]; sn_pend = 1;
                        end else begin
                            if (gwait < 0) gwait = int'($urandom % 4);
                            if (gwait > 0) gwait--;
                            else begin
                                bus_gnt = 1; gwait = -1;
                                if (ecmd[step] == 2'd3) begin
                                    mem[eadr[step]] = bus_wdata; ex_st[idx] = 0;
                                end else fill_cnt = 3;
                                step++;
                            end
                        end
                    end
                end
                @(negedge clk);
            end
        end
        if (!done) chk(rq, "request never completed", 0, 1);
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0;
        if (wr) begin
            ex_st[idx] = 2; ex_tag[idx] = tg; ex_dat[idx] = d;
        end else if (!hit) begin
            ex_st[idx] = 1; ex_tag[idx] = tg; ex_dat[idx] = mem[a];
        end
    endtask

    task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a);
        int idx;
        bit held, exp_ab;
        string rq;
        idx = int'(a[IW-1:0]);
        held = ex_st[idx] != 0 && ex_tag[idx] == a[AW-1:IW];
        exp_ab = held && ex_st[idx] == 2 && (cmd == 2'd1 || cmd == 2'd2);
        rq = (cmd == 2'd3 || !held) ? "R11" : (cmd == 2'd1 ? (ex_st[idx] == 2 ? "R9" : "R11") : "R10");
        #1;
        snp_vld = 1; snp_cmd = cmd; snp_addr = a;
        @(negedge clk);
        #1;
        snp_vld = 0;
        chk(rq, "snoop abort", snp_abort, exp_ab);
        if (exp_ab) chk(rq, "snoop data", snp_data, ex_dat[idx]);
        if (held && cmd == 2'd1 && ex_st[idx] == 2) begin
            ex_st[idx] = 1; mem[a] = ex_dat[idx];
        end else if (held && cmd == 2'd2) begin
            if (ex_st[idx] == 2) mem[a] = ex_dat[idx];
            ex_st[idx] = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(16'h1000 + i * 7);
        for (int i = 0; i < NL; i++) begin ex_st[i] = 0; ex_tag[i] = '0; ex_dat[i] = '0; end
        rst_n = 0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 0; bus_fill_vld = 0; bus_fill_data = '0;
        snp_vld = 0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "bus_req after reset", bus_req, 0);
        chk("R1", "snp_abort after reset", snp_abort, 0);
        chk("R1", "cpu_stall after reset", cpu_stall, 0);
        chk("R1", "cpu_done after reset", cpu_done, 0);

        cpu_op(0, 6'h05, '0, 0);          // R3 read miss
        cpu_op(0, 6'h05, '0, 0);          // R2 read hit
        cpu_op(1, 6'h05, 16'hA5A5, 0);    // R5 upgrade shared
        cpu_op(1, 6'h05, 16'h5A5A, 0);    // R4 exclusive write hit
        cpu_op(0, 6'h05, '0, 0);          // R4 read back
        cpu_op(0, 6'h15, '0, 0);          // R7 dirty eviction
        cpu_op(1, 6'h25, 16'h1234, 0);    // R6 write miss
        snoop(2'd3, 6'h25);               // R11 write-back snoop ignored
        cpu_op(1, 6'h25, 16'h4321, 0);    // still exclusive after R11
        cpu_op(0, 6'h35, '0, 1);          // R12 cancelled write-back
        snoop(2'd1, 6'h35);               // R11 shared, no abort
        snoop(2'd2, 6'h35);               // R10 invalidate
        cpu_op(0, 6'h35, '0, 0);          // R10 miss after invalidate
        cpu_op(1, 6'h02, 16'hBEEF, 0);
        snoop(2'd1, 6'h02);               // R9 owner supplies
        cpu_op(1, 6'h02, 16'hCAFE, 0);    // R9 now shared, write-miss
        snoop(2'd2, 6'h02);               // R10 exclusive invalidate with abort

        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a;
            int pick;
            a = AW'($urandom % 16);
            pick = int'($urandom % 10);
            if (pick < 4) cpu_op(0, a, '0, 0);
            else if (pick < 7) cpu_op(1, a, DW'($urandom), 0);
            else if (pick < 8) cpu_op(0, a, '0, 1);
            else snoop(2'(1 + $urandom % 3), a);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule